// File: doc/BRIEF.md
# Pipelined Pre-Add Dot-Product Engine

The engine accepts one signed sample per clock on a valid/data stream. For every sample it produces one signed result. Each result is a dot product over `TAPS` terms. Every term first adds the sample to an older sample, then multiplies that sum by a coefficient taken from a rotating ring. All taps are laid out as a feed-forward pipeline.

The current sample travels through a per-tap register chain, so no net has to drive every tap. The partial sums pass through a registered linear chain of adders rather than through an adder tree. The pipeline advances only on accepted samples. Input bubbles therefore freeze every chain, the ring and the valid tracking, and the sequence of results does not depend on where the bubbles fall. Coefficients are shifted in one word at a time on a separate port while the sample stream is idle.

Top module: `preadd_dot_engine`

## Requirements
- R1: Number accepted samples x_0, x_1, ... from the last reset. Let s_k be the ring rotation count at the moment x_k is accepted, and let C[p] be coefficient position p. Result k equals the sum over j = 0..TAPS-1 of (x_k + x_{k-1-j}) * C[(s_k + 2j + 1) mod TAPS]. Samples with a negative index count as 0.
- R2: Each accepted sample rotates the ring by exactly one position. After r rotations, tap j reads position (j + r) mod TAPS. The rotation count is measured from the last completed load of TAPS words.
- R3: The result is signed and `2*DW+1+log2(TAPS)` bits wide (39 bits by default). It holds any sum of full-scale terms without overflow, including the case where every sample and every coefficient is -32768.
- R4: `out_valid_o` is high for exactly one cycle, in the cycle after the accepted sample with index k+TAPS+1. At that point it carries result k. It is never high in any other cycle.
- R5: A cycle with `in_valid_i` low accepts nothing, leaves the ring unrotated and leaves `out_data_o` unchanged. The result values are the same with or without bubbles.
- R6: Each cycle with `coef_valid_i` high shifts `coef_i` into the ring at position TAPS-1 and moves the other positions down by one, with no rotation. After TAPS such words, the word loaded i-th (counting from 0) sits at position i.
- R7: Reset (`rst_ni` low) clears the sample chains, the partial sums, `out_data_o` and the valid tracking. It keeps both the ring contents and the ring rotation.
- R8: A cycle with `in_valid_i` and `coef_valid_i` both high performs the load only. The sample is dropped, and neither the sample history nor the result count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | DW | Signed sample |
| coef_valid_i | input | 1 | Coefficient load strobe |
| coef_i | input | CW | Signed coefficient word |
| out_valid_o | output | 1 | Result strobe |
| out_data_o | output | 2*DW+1+log2(TAPS) | Signed result |

## Verification
Two behaviours are the hardest to reach from the ports. One is a reset that falls in the middle of a stream while the ring sits at a non-zero rotation. The other is a load word that arrives together with a sample strobe. The stimulus covers both. It resets after an odd number of samples and streams again without reloading, so the expected coefficients depend on the rotation carried across the reset. It also holds the sample strobe high with non-zero data during an entire load. Any sample accepted by mistake would then shift both the history and the coefficient index of every later result.

// File: rtl/preadd_dot_pkg.sv
package preadd_dot_pkg;
  function automatic int prod_width(input int dw, input int cw);
    return dw + 1 + cw;
  endfunction

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return prod_width(dw, cw) + $clog2(taps);
  endfunction
endpackage

// File: rtl/pdot_delay_line.sv
module pdot_delay_line #(
  parameter int DW     = 16,
  parameter int LEN    = 64,
  parameter int STRIDE = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic [DW-1:0]           din_i,
  output logic [LEN-1:0][DW-1:0]  tap_o
);
  localparam int DEPTH = LEN * STRIDE;

  logic [DEPTH-1:0][DW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
    end else if (step_i) begin
      line_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  // stage j taps the last register of its stride group
  for (genvar j = 0; j < LEN; j++) begin : g_tap
    assign tap_o[j] = line_q[j*STRIDE + STRIDE - 1];
  end

  a_r1_chain_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> line_q[0] == $past(din_i));
  a_r5_chain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> line_q[DEPTH-1] == $past(line_q[DEPTH-1]));
endmodule

// File: rtl/pdot_coef_ring.sv
module pdot_coef_ring #(
  parameter int CW   = 16,
  parameter int TAPS = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    load_i,
  input  logic [CW-1:0]           coef_i,
  output logic [TAPS-1:0][CW-1:0] coef_o
);
  logic [TAPS-1:0][CW-1:0] ring_q;

  // no reset: contents survive a pipeline reset
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      for (int i = 0; i < TAPS-1; i++) ring_q[i] <= ring_q[i+1];
      ring_q[TAPS-1] <= coef_i;
    end else if (step_i) begin
      for (int i = 0; i < TAPS-1; i++) ring_q[i] <= ring_q[i+1];
      ring_q[TAPS-1] <= ring_q[0];
    end
  end

  assign coef_o = ring_q;

  a_r2_rotate_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ring_q[TAPS-1] == $past(ring_q[0]));
  a_r2_rotate_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ring_q[0] == $past(ring_q[1]));
  a_r6_load_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ring_q[TAPS-1] == $past(coef_i));
endmodule

// File: rtl/pdot_mac_stage.sv
module pdot_mac_stage #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int PW = 33,
  parameter int AW = 39
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] opa_i,
  input  logic [CW-1:0] coef_i,
  input  logic [AW-1:0] psum_i,
  output logic [AW-1:0] psum_o
);
  localparam int GW = AW - PW;

  logic signed [DW:0]    pre_sum;
  logic signed [CW-1:0]  coef_s;
  logic signed [PW-1:0]  prod_d;
  logic        [PW-1:0]  prod_q;
  logic        [AW-1:0]  psum_q;

  assign pre_sum = {smp_i[DW-1], smp_i} + {opa_i[DW-1], opa_i};
  assign coef_s  = coef_i;
  assign prod_d  = pre_sum * coef_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      psum_q <= '0;
    end else if (step_i) begin
      prod_q <= prod_d;
      psum_q <= psum_i + {{GW{prod_q[PW-1]}}, prod_q};
    end
  end

  assign psum_o = psum_q;

  a_r5_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> psum_o == $past(psum_o));
endmodule

// File: rtl/pdot_fill_track.sv
module pdot_fill_track #(
  parameter int DEPTH = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic out_valid_o
);
  logic [DEPTH-1:0] fill_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= step_i & fill_q[DEPTH-1];
      if (step_i) fill_q <= {fill_q[DEPTH-2:0], 1'b1};
    end
  end

  assign out_valid_o = vld_q;

  a_r4_pulse_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(step_i));
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !step_i) |=> !out_valid_o);
endmodule

// File: rtl/preadd_dot_engine.sv
module preadd_dot_engine
  import preadd_dot_pkg::*;
#(
  parameter int TAPS = 64,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int PW  = prod_width(DW, CW),
  localparam int AW  = acc_width(DW, CW, TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          coef_valid_i,
  input  logic [CW-1:0] coef_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_data_o
);
  logic                    step;
  logic [TAPS-1:0][DW-1:0] smp_tap;
  logic [TAPS-1:0][DW-1:0] opa_tap;
  logic [TAPS-1:0][CW-1:0] coef_tap;
  logic [AW-1:0]           psum_w [TAPS+1];

  // a load cycle drops any concurrent sample
  assign step = in_valid_i & ~coef_valid_i;

  pdot_delay_line #(.DW(DW), .LEN(TAPS), .STRIDE(1)) u_smp_line (
    .clk_i, .rst_ni, .step_i(step), .din_i(in_data_i), .tap_o(smp_tap)
  );

  // two registers per tap: older operand lags by one extra sample per stage
  pdot_delay_line #(.DW(DW), .LEN(TAPS), .STRIDE(2)) u_opa_line (
    .clk_i, .rst_ni, .step_i(step), .din_i(in_data_i), .tap_o(opa_tap)
  );

  pdot_coef_ring #(.CW(CW), .TAPS(TAPS)) u_ring (
    .clk_i, .rst_ni, .step_i(step), .load_i(coef_valid_i), .coef_i, .coef_o(coef_tap)
  );

  assign psum_w[0] = '0;

  for (genvar j = 0; j < TAPS; j++) begin : g_stage
    pdot_mac_stage #(.DW(DW), .CW(CW), .PW(PW), .AW(AW)) u_mac (
      .clk_i,
      .rst_ni,
      .step_i (step),
      .smp_i  (smp_tap[j]),
      .opa_i  (opa_tap[j]),
      .coef_i (coef_tap[j]),
      .psum_i (psum_w[j]),
      .psum_o (psum_w[j+1])
    );
  end

  pdot_fill_track #(.DEPTH(TAPS+1)) u_fill (
    .clk_i, .rst_ni, .step_i(step), .out_valid_o
  );

  assign out_data_o = psum_w[TAPS];

  a_r5_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(out_data_o));
  a_r8_load_drops_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && coef_valid_i) |=> !out_valid_o);
endmodule

// File: tb/sim_preadd_dot_engine.sv
module sim_preadd_dot_engine;
  localparam int N  = 64;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int AW = 2*DW + 1 + $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          coef_valid_i = 1'b0;
  logic [CW-1:0] coef_i = '0;
  logic          out_valid_o;
  logic [AW-1:0] out_data_o;

  preadd_dot_engine #(.TAPS(N), .DW(DW), .CW(CW)) u0 (.*);

  always #2 clk_i = ~clk_i;

  int     checks = 0, fails = 0;
  int     xs[$];
  int     sk[$];
  int     cm[N];
  int     rot = 0;
  bit     exp_valid = 0, have_out = 0, done = 0;
  longint exp_data = 0, last_out = 0;
  string  cur_req = "R1";
  bit [31:0] seed = 32'h1234_5678;

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:8]));
  endfunction

  function automatic longint ref_result(int k);
    longint y = 0;
    for (int j = 0; j < N; j++) begin
      longint a = xs[k];
      longint b = (k - 1 - j >= 0) ? xs[k-1-j] : 0;
      y += (a + b) * longint'(cm[(sk[k] + 1 + 2*j) % N]);
    end
    return y;
  endfunction

  task automatic check_outputs();
    longint got = longint'($signed(out_data_o));
    checks++;
    if (out_valid_o !== exp_valid) begin
      fails++;
      $display("FAIL R4: out_valid_o=%0b expected %0b", out_valid_o, exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (got != exp_data) begin
        fails++;
        $display("FAIL %s: out_data_o=%0d expected %0d", cur_req, got, exp_data);
      end
      last_out = exp_data;
      have_out = 1;
    end else if (have_out) begin
      checks++;
      if (got != last_out) begin
        fails++;
        $display("FAIL R5: held out_data_o=%0d expected %0d", got, last_out);
      end
    end
  endtask

  task automatic tick(bit v, int d, bit cv, int cd);
    @(negedge clk_i);
    check_outputs();
    in_valid_i = v; in_data_i = DW'(d); coef_valid_i = cv; coef_i = CW'(cd);
    exp_valid = 0;
    if (cv) begin
      for (int i = 0; i < N-1; i++) cm[i] = cm[i+1];
      cm[N-1] = cd;
      rot = 0;
    end else if (v) begin
      int t;
      xs.push_back(d);
      sk.push_back(rot);
      rot = (rot + 1) % N;
      t = xs.size() - 1;
      if (t >= N + 1) begin
        exp_valid = 1;
        exp_data = ref_result(t - 1 - N);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    check_outputs();
    rst_ni = 1'b0; in_valid_i = 0; coef_valid_i = 0;
    xs.delete(); sk.delete();
    exp_valid = 0; have_out = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0 || out_data_o !== '0) begin
      fails++;
      $display("FAIL R7: reset state valid=%0b data=%0d expected 0/0", out_valid_o, out_data_o);
    end
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6/R8: full load with a sample strobe held high that must be dropped
    cur_req = "R8";
    for (int i = 0; i < N; i++) tick(1, 1234 + i, 1, (i * 523) % 4001 - 2000);
    // R1/R2: continuous stream
    cur_req = "R1";
    for (int i = 0; i < 140; i++) tick(1, rnd16(), 0, 0);
    // R5: bubbles, including a long gap
    cur_req = "R5";
    for (int i = 0; i < 120; i++) begin
      tick((i % 3) != 1, rnd16(), 0, 0);
      if (i == 60) for (int g = 0; g < 7; g++) tick(0, 0, 0, 0);
    end
    // R7: reset mid-stream at odd rotation, no reload
    cur_req = "R7";
    for (int i = 0; i < 13; i++) tick(1, rnd16(), 0, 0);
    do_reset();
    for (int i = 0; i < 100; i++) tick(1, rnd16(), 0, 0);
    // R2/R6: single non-zero coefficient, ramp input
    do_reset();
    cur_req = "R2";
    for (int i = 0; i < N; i++) tick(0, 0, 1, (i == 5) ? 1 : 0);
    for (int i = 0; i < 100; i++) tick(1, i * 17 - 800, 0, 0);
    // R3: full-scale negative samples and coefficients
    do_reset();
    cur_req = "R3";
    for (int i = 0; i < N; i++) tick(0, 0, 1, -32768);
    for (int i = 0; i < 100; i++) tick(1, -32768, 0, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule